// File: doc/BRIEF.md
# Memory-mapped GPIO port with atomic bit aliases

This block is one 32-pin general-purpose I/O port attached to a simple register bus. It holds two state registers, pin direction and output data, and gives each of them four word addresses: one that replaces the value and three alias addresses that clear, set or invert only the bits written as 1. Software can therefore change a single pin without a read-modify-write sequence. A third word returns the pin levels after a two-flop synchroniser.

The port drives each pad with an output enable, an output value and a pair of pull controls. A per-pin pull-enable input comes from a separate configuration block. When a pin has its pull enabled and is an input, its output-data bit picks the pull direction: 1 pulls up, 0 pulls down. Each port decodes a 128-byte window, so a second instance can sit 0x80 above the first.

Bus writes take effect at the clock edge where `bus_we` is sampled high. Reads are combinational from the addressed word. The reset input is asynchronous and active low. Inside the block its release is synchronised, so the registers leave reset two clocks after `rst_n` rises.

Top module: `gpio_port`

## Requirements
- R1: After reset, direction and output data are all zero, so every `pad_oe` bit is 0 and no pull is active unless `pull_en` is set.
- R2: A write to byte offset 0x00 (direction) loads the strobed bytes of `bus_wdata` into the direction register.
- R3: A write to offset 0x04 (direction clear) makes each pin whose written bit is 1 an input. Bits written 0 leave their pins unchanged.
- R4: A write to offset 0x08 (direction set) makes each pin whose written bit is 1 an output. Bits written 0 leave their pins unchanged.
- R5: A write to offset 0x0C (direction toggle) inverts the direction of each pin whose written bit is 1.
- R6: A write to offset 0x10 (output data) with all four byte strobes set replaces all 32 output bits at once.
- R7: Writes to offsets 0x14, 0x18 and 0x1C clear, set and invert, in that order, the output bits where 1s are written. All other output bits keep their value.
- R8: Bit `bus_be[b]` enables bits 8b+7 to 8b of a write, for every write kind. Bytes whose strobe is 0 are unchanged.
- R9: Reads of offsets 0x00 to 0x0C return the direction register, and reads of offsets 0x10 to 0x1C return the output register. Offsets 0x24 to 0x7F and any address with bits [1:0] not zero read as zero, and writes to them have no effect.
- R10: Offset 0x20 returns the pin levels sampled at the second-to-last clock edge. A pin change applied before edge k is visible after edge k+1. Writes to 0x20 are ignored.
- R11: `pad_oe` equals the direction register (1 = output), and `pad_out` equals the output register.
- R12: `pad_pull_up` is high for a pin that has `pull_en` set, is an input, and has its output bit at 1. `pad_pull_dn` is high under the same conditions with the output bit at 0. Both pulls are low for an output pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| bus_addr | input | 7 | Byte address within the port window |
| bus_we | input | 1 | Write enable |
| bus_be | input | 4 | Byte strobes for the write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | 32 | Pin levels from the pads (asynchronous) |
| pull_en | input | 32 | Per-pin pull enable from the configuration block |
| pad_oe | output | 32 | Per-pin output enable |
| pad_out | output | 32 | Per-pin output value |
| pad_pull_up | output | 32 | Per-pin pull-up enable |
| pad_pull_dn | output | 32 | Per-pin pull-down enable |

## Verification
The bench aims alias writes at registers that already hold mixed patterns. A clear or set that disturbs the zero-written bits, or a toggle implemented as a set, shows up as wrong neighbouring bits. Partial byte strobes go to every write kind, so a decoder that ignores strobes on the alias paths changes bytes that should stay unchanged. Pin patterns change every cycle and the input word is read back in each of them. An input path that is one stage short or one stage long then returns the wrong sample. The pull outputs are checked while pins switch between input and output with both output values, which catches a design that keeps a pull on for an output pin or picks the wrong polarity.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_WR,
    OP_CLR,
    OP_SET,
    OP_TGL
  } wr_op_e;

  // word index inside the port window
  localparam int unsigned W_DIR     = 0;
  localparam int unsigned W_DIR_CLR = 1;
  localparam int unsigned W_DIR_SET = 2;
  localparam int unsigned W_DIR_TGL = 3;
  localparam int unsigned W_OUT     = 4;
  localparam int unsigned W_OUT_CLR = 5;
  localparam int unsigned W_OUT_SET = 6;
  localparam int unsigned W_OUT_TGL = 7;
  localparam int unsigned W_IN      = 8;

  // low two words of a group select the operation
  function automatic wr_op_e op_of(input logic [1:0] sub);
    case (sub)
      2'd0:    op_of = OP_WR;
      2'd1:    op_of = OP_CLR;
      2'd2:    op_of = OP_SET;
      default: op_of = OP_TGL;
    endcase
  endfunction

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] s1_q, s2_q;
  logic [W-1:0] s1_d, s2_d;

  always_comb begin
    s1_d = d;
    s2_d = s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign q = s2_q;

  // warm-up count so the latency check never looks before reset
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  p_two_clock_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wr_op_e       op,
  input  logic [W-1:0] wmask,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic [W-1:0] hit;
  logic         en;

  always_comb begin
    hit = wdata & wmask;
    en  = (op != OP_NONE);
    case (op)
      OP_WR:   q_nxt = (q_r & ~wmask) | hit;
      OP_CLR:  q_nxt = q_r & ~hit;
      OP_SET:  q_nxt = q_r | hit;
      OP_TGL:  q_nxt = q_r ^ hit;
      default: q_nxt = q_r;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (en) q_r <= q_nxt;
  end

  assign q = q_r;

  p_clear_never_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CLR) |=> ((q & ~$past(q)) == '0));

  p_set_never_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SET) |=> (($past(q) & ~q) == '0));

  p_unstrobed_bytes_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_NONE) |=> ((($past(q) ^ q) & ~$past(wmask)) == '0));

  p_idle_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_NONE) |=> $stable(q));

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] dout,
  input  logic [W-1:0] pull_en,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pull_up,
  output logic [W-1:0] pad_pull_dn
);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic pull_act;
    assign pull_act       = pull_en[i] & ~dir[i];
    assign pad_oe[i]      = dir[i];
    assign pad_out[i]     = dout[i];
    assign pad_pull_up[i] = pull_act & dout[i];
    assign pad_pull_dn[i] = pull_act & ~dout[i];
  end

  p_output_pin_no_pull_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & (pad_pull_up | pad_pull_dn)) == '0));

  p_pull_one_way_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pull_up & pad_pull_dn) == '0));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NPINS/8-1:0] bus_be,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  input  logic [NPINS-1:0]  pull_en,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_pull_up,
  output logic [NPINS-1:0]  pad_pull_dn
);

  localparam int unsigned NBYTES = NPINS / 8;
  localparam int unsigned WIDX_W = ADDR_W - 2;

  logic              rst_n_i;
  logic [WIDX_W-1:0] widx;
  logic              aligned;
  logic [NPINS-1:0]  wmask;
  wr_op_e            dir_op, out_op;
  logic [NPINS-1:0]  dir_q, out_q, in_q;

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  for (genvar b = 0; b < NBYTES; b++) begin : g_be
    assign wmask[b*8 +: 8] = {8{bus_be[b]}};
  end

  always_comb begin
    widx    = bus_addr[ADDR_W-1:2];
    aligned = (bus_addr[1:0] == 2'b00);
    dir_op  = OP_NONE;
    out_op  = OP_NONE;
    if (bus_we && aligned) begin
      if (widx >= WIDX_W'(W_DIR) && widx <= WIDX_W'(W_DIR_TGL))
        dir_op = op_of(widx[1:0]);
      else if (widx >= WIDX_W'(W_OUT) && widx <= WIDX_W'(W_OUT_TGL))
        out_op = op_of(widx[1:0]);
    end
  end

  gpio_alias_reg #(.W(NPINS)) u_dir (
    .clk   (clk),
    .rst_n (rst_n_i),
    .op    (dir_op),
    .wmask (wmask),
    .wdata (bus_wdata),
    .q     (dir_q)
  );

  gpio_alias_reg #(.W(NPINS)) u_out (
    .clk   (clk),
    .rst_n (rst_n_i),
    .op    (out_op),
    .wmask (wmask),
    .wdata (bus_wdata),
    .q     (out_q)
  );

  gpio_in_sync #(.W(NPINS)) u_in (
    .clk   (clk),
    .rst_n (rst_n_i),
    .d     (pin_in),
    .q     (in_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      if (widx <= WIDX_W'(W_DIR_TGL))      bus_rdata = dir_q;
      else if (widx <= WIDX_W'(W_OUT_TGL)) bus_rdata = out_q;
      else if (widx == WIDX_W'(W_IN))      bus_rdata = in_q;
    end
  end

  gpio_pad_ctrl #(.W(NPINS)) u_pad (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .dir         (dir_q),
    .dout        (out_q),
    .pull_en     (pull_en),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out),
    .pad_pull_up (pad_pull_up),
    .pad_pull_dn (pad_pull_dn)
  );

  p_reset_all_inputs_r1: assert property (@(posedge clk)
    (!rst_n_i) |-> (pad_oe == '0));

  p_no_write_no_change_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!bus_we) |=> ($stable(pad_oe) && $stable(pad_out)));

  p_input_word_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n_i)
    (bus_we && bus_addr == ADDR_W'(W_IN * 4)) |=> ($stable(pad_oe) && $stable(pad_out)));

endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  bus_addr;
  logic        bus_we;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pull_en;
  logic [31:0] pad_oe, pad_out, pad_pull_up, pad_pull_dn;

  int    n_vec = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  logic [31:0] m_dir = '0, m_out = '0, m_in1 = '0, m_in2 = '0;

  always #4 clk = ~clk;

  gpio_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pull_en(pull_en), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_pull_up(pad_pull_up), .pad_pull_dn(pad_pull_dn)
  );

  function automatic logic [31:0] exp_rdata(input logic [6:0] a);
    if (a[1:0] != 2'b00) return '0;
    if (a < 7'h10)       return m_dir;
    if (a < 7'h20)       return m_out;
    if (a == 7'h20)      return m_in2;
    return '0;
  endfunction

  task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  task automatic check_now();
    n_vec++;
    cmp("rdata",   bus_rdata,   exp_rdata(bus_addr));
    cmp("pad_oe",  pad_oe,      m_dir);
    cmp("pad_out", pad_out,     m_out);
    cmp("pull_up", pad_pull_up, pull_en & ~m_dir & m_out);
    cmp("pull_dn", pad_pull_dn, pull_en & ~m_dir & ~m_out);
  endtask

  // one clock: check outputs, drive inputs, advance the model at the edge
  task automatic step(input string req, input logic [6:0] a, input logic we,
                      input logic [3:0] be, input logic [31:0] wd,
                      input logic [31:0] pins, input logic [31:0] pull);
    logic [31:0] msk, hit;
    @(negedge clk);
    check_now();
    cur_req   = req;
    bus_addr  = a;
    bus_we    = we;
    bus_be    = be;
    bus_wdata = wd;
    pin_in    = pins;
    pull_en   = pull;
    @(posedge clk);
    msk = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    hit = wd & msk;
    if (we && a[1:0] == 2'b00) begin
      case (a[6:2])
        5'd0: m_dir = (m_dir & ~msk) | hit;
        5'd1: m_dir = m_dir & ~hit;
        5'd2: m_dir = m_dir | hit;
        5'd3: m_dir = m_dir ^ hit;
        5'd4: m_out = (m_out & ~msk) | hit;
        5'd5: m_out = m_out & ~hit;
        5'd6: m_out = m_out | hit;
        5'd7: m_out = m_out ^ hit;
        default: ;
      endcase
    end
    m_in2 = m_in1;
    m_in1 = pins;
  endtask

  task automatic rd(input string req, input logic [6:0] a, input logic [31:0] pins,
                    input logic [31:0] pull);
    step(req, a, 1'b0, 4'h0, 32'h0, pins, pull);
  endtask

  task automatic wr(input string req, input logic [6:0] a, input logic [3:0] be,
                    input logic [31:0] wd);
    step(req, a, 1'b1, be, wd, pin_in, pull_en);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_be = '0; bus_wdata = '0;
    pin_in = '0; pull_en = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state observed while held in reset
    check_now();
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset values readable
    rd("R1", 7'h00, '0, '0);
    rd("R1", 7'h10, '0, 32'hFFFF_FFFF);
    rd("R1", 7'h00, '0, '0);
    // R2 direct direction write, R11 pads follow
    wr("R2", 7'h00, 4'hF, 32'hA5A5_0F0F);
    rd("R11", 7'h00, '0, '0);
    // R8 partial strobes on direct write
    wr("R8", 7'h00, 4'b0101, 32'h1234_5678);
    rd("R8", 7'h00, '0, '0);
    // R3 clear alias
    wr("R3", 7'h04, 4'hF, 32'hF000_000F);
    rd("R3", 7'h04, '0, '0);
    // R4 set alias
    wr("R4", 7'h08, 4'hF, 32'h0000_F0F0);
    rd("R4", 7'h08, '0, '0);
    // R5 toggle alias, twice on overlapping bits
    wr("R5", 7'h0C, 4'hF, 32'hFF00_FF00);
    rd("R5", 7'h0C, '0, '0);
    wr("R5", 7'h0C, 4'hF, 32'h0F0F_0F0F);
    rd("R5", 7'h00, '0, '0);
    // R6 full output write
    wr("R6", 7'h10, 4'hF, 32'hDEAD_BEEF);
    rd("R6", 7'h10, '0, '0);
    wr("R6", 7'h10, 4'hF, 32'h0123_4567);
    rd("R6", 7'h10, '0, '0);
    // R7 output clear, set, toggle
    wr("R7", 7'h14, 4'hF, 32'h0000_00FF);
    rd("R7", 7'h14, '0, '0);
    wr("R7", 7'h18, 4'hF, 32'hF000_0001);
    rd("R7", 7'h18, '0, '0);
    wr("R7", 7'h1C, 4'hF, 32'h8000_FFFF);
    rd("R7", 7'h1C, '0, '0);
    // R8 strobes on every alias kind
    wr("R8", 7'h14, 4'b1000, 32'hFFFF_FFFF);
    wr("R8", 7'h18, 4'b0010, 32'hFFFF_FFFF);
    wr("R8", 7'h1C, 4'b0001, 32'hFFFF_FFFF);
    wr("R8", 7'h04, 4'b0100, 32'hFFFF_FFFF);
    wr("R8", 7'h08, 4'b0001, 32'hFFFF_FFFF);
    wr("R8", 7'h0C, 4'b1000, 32'hFFFF_FFFF);
    wr("R8", 7'h10, 4'b0000, 32'hFFFF_FFFF);
    rd("R8", 7'h10, '0, '0);
    // R9 unused, misaligned, and out-of-range offsets
    rd("R9", 7'h24, '0, '0);
    rd("R9", 7'h7C, '0, '0);
    rd("R9", 7'h11, '0, '0);
    wr("R9", 7'h40, 4'hF, 32'hFFFF_FFFF);
    wr("R9", 7'h05, 4'hF, 32'hFFFF_FFFF);
    wr("R9", 7'h13, 4'hF, 32'h0000_0000);
    rd("R9", 7'h00, '0, '0);
    // R10 input synchroniser, changing patterns each cycle
    rd("R10", 7'h20, 32'h0000_0001, '0);
    rd("R10", 7'h20, 32'hCAFE_F00D, '0);
    rd("R10", 7'h20, 32'h5555_AAAA, '0);
    rd("R10", 7'h20, 32'h5555_AAAA, '0);
    rd("R10", 7'h20, 32'hFFFF_0000, '0);
    wr("R10", 7'h20, 4'hF, 32'hFFFF_FFFF);
    rd("R10", 7'h20, 32'h0000_0000, '0);
    rd("R10", 7'h20, 32'h0000_0000, '0);
    rd("R10", 7'h00, 32'h0000_0000, '0);
    // R12 pulls with mixed direction and output
    wr("R12", 7'h00, 4'hF, 32'h0000_FFFF);
    wr("R12", 7'h10, 4'hF, 32'h00FF_00FF);
    rd("R12", 7'h10, '0, 32'hFFFF_FFFF);
    rd("R12", 7'h10, '0, 32'h0F0F_0F0F);
    wr("R12", 7'h1C, 4'hF, 32'hFFFF_FFFF);
    rd("R12", 7'h10, '0, 32'hFFFF_FFFF);
    wr("R12", 7'h04, 4'hF, 32'hFFFF_FFFF);
    rd("R12", 7'h10, '0, 32'hFFFF_FFFF);
    wr("R12", 7'h08, 4'hF, 32'hFFFF_FFFF);
    rd("R11", 7'h10, '0, 32'hFFFF_FFFF);
    rd("R11", 7'h00, '0, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule